// File: doc/BRIEF.md
# Attribute Controller Host Port

This block is the host-side front end of a display attribute controller. The host reaches it through a small byte-wide register window. The first location is a single write port. A phase toggle inside the block makes writes to that port alternate: one write carries an index byte and the next carries a data byte for the register that the index selected. After each data byte the toggle goes back to the index phase.

The host often cannot know which phase the toggle is in. To resynchronise, it reads the input status location. That read returns a status byte supplied by the display timing logic, and as a side effect it forces the toggle into the index phase. The register selected by the latched index is read back at the next address up. The first location, when read, returns the latched index byte.

The block holds 21 byte-wide attribute registers and presents all of them in parallel to the pixel logic. The first 16 of them are palette entries. One bit of the index byte decides who owns those entries. When the bit is set, the display owns them and host data writes to them are dropped. When it is clear, the host may write them. The bit is exported as a flag for the palette logic.

Top module: `attr_port`

## Requirements
- R1: While rst_n is low at a clock edge, the toggle enters the index phase, the latched index becomes 0x00, pal_disp_en becomes 1, and every attribute register becomes 0x00.
- R2: In the index phase, a write to address 0 latches the index and moves the toggle to the data phase. In the data phase, a write to address 0 stores bus_wdata into the selected register and returns the toggle to the index phase.
- R3: A read of address 2 returns status_in on bus_rdata in the same cycle. At the next edge it forces the toggle into the index phase, so the following write to address 0 is taken as an index.
- R4: A read of address 1 returns the selected register. A read of address 0 returns {2'b00, palette bit, 5-bit index}. Neither read changes the toggle or any register.
- R5: Only index bits 4:0 select a register, and bits 7:6 are discarded. Index bit 5 is latched as pal_disp_en, where 1 means the display owns the palette. pal_disp_en changes only on an index-phase write.
- R6: A data write to index 0x00–0x0F while pal_disp_en is 1 leaves the register unchanged. The toggle still returns to the index phase.
- R7: Indices 0x10–0x14 accept data writes whatever the value of pal_disp_en.
- R8: For indices 0x15–0x1F, a data write is discarded, and a read of address 1 returns 0x00.
- R9: attr_q bits [8*i+7:8*i] always equal attribute register i.
- R10: bus_rdata is 0x00 when bus_rd is low, and a read of address 3 returns 0x00. Writes to addresses 1, 2 and 3 change neither the toggle nor any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_addr | input | 2 | 0 index/data port, 1 data readback, 2 status, 3 unused |
| bus_wdata | input | 8 | Host write byte |
| status_in | input | 8 | Status byte from display timing logic |
| bus_rdata | output | 8 | Read byte, valid in the cycle bus_rd is high |
| pal_disp_en | output | 1 | 1 when the display owns palette entries 0x00–0x0F |
| attr_q | output | 168 | All 21 attribute registers, register i at bits 8i+7:8i |

## Verification
Some properties are checked by assertions on every cycle:
- a status read leaves the toggle in the index phase;
- every port write flips the toggle;
- the palette flag moves only on an index write;
- palette bytes hold still while the display owns them;
- the read bus stays quiet when idle;
- stray writes to addresses 1, 2 and 3 change nothing.

Other behaviour can only be shown by the bench scenarios, because it depends on data values:
- which register a data byte lands in after index bits 7:6 are discarded;
- that readback returns the stored byte;
- the boundaries at 0x0F/0x10 and 0x14/0x15;
- resynchronisation in the middle of a pair, with a status read between an index write and its data write.

// File: rtl/attr_pkg.sv
// Package: shared constants and types for the attribute host port.
// Assumes a 2-bit host address window and byte-wide accesses.
package attr_pkg;
    localparam int ATTR_DW      = 8;
    localparam int ATTR_NUM     = 21;
    localparam int ATTR_PAL     = 16;
    localparam int ATTR_IDX_W   = 5;
    localparam int ATTR_PAL_BIT = 5;
    localparam int ATTR_AW      = 2;

    localparam logic [ATTR_AW-1:0] A_PORT = 2'd0;
    localparam logic [ATTR_AW-1:0] A_DRD  = 2'd1;
    localparam logic [ATTR_AW-1:0] A_STAT = 2'd2;

    typedef enum logic {
        PH_INDEX = 1'b0,
        PH_DATA  = 1'b1
    } phase_e;
endpackage

// File: rtl/attr_flipflop.sv
// Module: index/data phase toggle and index latch.
// Assumes port_wr and stat_rd are single-cycle strobes. The status read
// clears the phase; they cannot coincide since they use different addresses.
module attr_flipflop
    import attr_pkg::*;
#(
    parameter int IDX_W   = ATTR_IDX_W,
    parameter int PAL_BIT = ATTR_PAL_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_wr,
    input  logic              stat_rd,
    input  logic [PAL_BIT:0]  idx_byte,
    output phase_e            phase,
    output logic [IDX_W-1:0]  idx,
    output logic              pal_disp,
    output logic              data_wr
);
    phase_e phase_q;
    logic   idx_wr;

    // Decode which kind of port write this cycle carries.
    always_comb begin
        idx_wr  = port_wr && (phase_q == PH_INDEX);
        data_wr = port_wr && (phase_q == PH_DATA);
    end

    // Phase toggle: status read rearms, port write flips.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_INDEX;
        end else if (stat_rd) begin
            phase_q <= PH_INDEX;
        end else if (idx_wr) begin
            phase_q <= PH_DATA;
        end else if (data_wr) begin
            phase_q <= PH_INDEX;
        end
    end

    // Index latch: register select and palette ownership bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            pal_disp <= 1'b1;
        end else if (idx_wr) begin
            idx      <= idx_byte[IDX_W-1:0];
            pal_disp <= idx_byte[PAL_BIT];
        end
    end

    assign phase = phase_q;
endmodule

// File: rtl/attr_regfile.sv
// Module: attribute register file with palette write lock.
// Assumes at most one data write per cycle. Indices at or above NUM
// select nothing. Entries below PAL are locked while pal_disp is set.
module attr_regfile #(
    parameter int DW    = 8,
    parameter int NUM   = 21,
    parameter int PAL   = 16,
    parameter int IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic              pal_disp,
    input  logic [DW-1:0]     wdata,
    output logic [NUM*DW-1:0] regs_flat,
    output logic [DW-1:0]     sel_data,
    output logic              sel_valid
);
    logic [DW-1:0] regs [NUM];

    genvar gi;
    generate
        for (gi = 0; gi < NUM; gi++) begin : g_reg
            localparam bit IS_PAL = (gi < PAL);
            logic hit;
            // Per-register write enable, with the palette lock applied.
            always_comb begin
                hit = wr_en && (idx == IDX_W'(gi)) && !(IS_PAL && pal_disp);
            end
            // Storage byte for register gi.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs[gi] <= '0;
                end else if (hit) begin
                    regs[gi] <= wdata;
                end
            end
            assign regs_flat[gi*DW +: DW] = regs[gi];
        end
    endgenerate

    // Select the indexed register for readback.
    always_comb begin
        sel_data  = '0;
        sel_valid = 1'b0;
        for (int i = 0; i < NUM; i++) begin
            if (idx == IDX_W'(i)) begin
                sel_data  = regs[i];
                sel_valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/attr_rdmux.sv
// Module: host read data multiplexer.
// Assumes a combinational read: data is valid in the cycle bus_rd is high.
module attr_rdmux
    import attr_pkg::*;
#(
    parameter int DW      = ATTR_DW,
    parameter int IDX_W   = ATTR_IDX_W,
    parameter int PAL_BIT = ATTR_PAL_BIT
) (
    input  logic               rd,
    input  logic [ATTR_AW-1:0] addr,
    input  logic [IDX_W-1:0]   idx,
    input  logic               pal_disp,
    input  logic [DW-1:0]      sel_data,
    input  logic               sel_valid,
    input  logic [DW-1:0]      status_in,
    output logic [DW-1:0]      rdata
);
    logic [DW-1:0] idx_byte;

    // Rebuild the latched index byte for readback.
    always_comb begin
        idx_byte = '0;
        idx_byte[IDX_W-1:0] = idx;
        idx_byte[PAL_BIT]   = pal_disp;
    end

    // Route the addressed source to the read bus.
    always_comb begin
        rdata = '0;
        if (rd) begin
            case (addr)
                A_PORT:  rdata = idx_byte;
                A_DRD:   rdata = sel_valid ? sel_data : '0;
                A_STAT:  rdata = status_in;
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/attr_port.sv
// Module: top of the attribute host port.
// Combines the phase toggle, the register file and the read multiplexer.
// Assumes the host raises at most one of bus_wr and bus_rd per cycle.
module attr_port
    import attr_pkg::*;
#(
    parameter int DW      = ATTR_DW,
    parameter int NUM     = ATTR_NUM,
    parameter int PAL     = ATTR_PAL,
    parameter int IDX_W   = ATTR_IDX_W,
    parameter int PAL_BIT = ATTR_PAL_BIT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ATTR_AW-1:0] bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    input  logic [DW-1:0]      status_in,
    output logic [DW-1:0]      bus_rdata,
    output logic               pal_disp_en,
    output logic [NUM*DW-1:0]  attr_q
);
    logic             port_wr;
    logic             stat_rd;
    logic             data_wr;
    phase_e           phase;
    logic             phase_is_data;
    logic [IDX_W-1:0] idx;
    logic [DW-1:0]    sel_data;
    logic             sel_valid;

    // Decode host strobes by address.
    always_comb begin
        port_wr       = bus_wr && (bus_addr == A_PORT);
        stat_rd       = bus_rd && (bus_addr == A_STAT);
        phase_is_data = (phase == PH_DATA);
    end

    attr_flipflop #(.IDX_W(IDX_W), .PAL_BIT(PAL_BIT)) u_ff (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_wr  (port_wr),
        .stat_rd  (stat_rd),
        .idx_byte (bus_wdata[PAL_BIT:0]),
        .phase    (phase),
        .idx      (idx),
        .pal_disp (pal_disp_en),
        .data_wr  (data_wr)
    );

    attr_regfile #(.DW(DW), .NUM(NUM), .PAL(PAL), .IDX_W(IDX_W)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (data_wr),
        .idx       (idx),
        .pal_disp  (pal_disp_en),
        .wdata     (bus_wdata),
        .regs_flat (attr_q),
        .sel_data  (sel_data),
        .sel_valid (sel_valid)
    );

    attr_rdmux #(.DW(DW), .IDX_W(IDX_W), .PAL_BIT(PAL_BIT)) u_rd (
        .rd        (bus_rd),
        .addr      (bus_addr),
        .idx       (idx),
        .pal_disp  (pal_disp_en),
        .sel_data  (sel_data),
        .sel_valid (sel_valid),
        .status_in (status_in),
        .rdata     (bus_rdata)
    );
endmodule

// File: rtl/attr_port_chk.sv
// Module: assertion checker attached to attr_port by bind.
// Observes ports plus the phase toggle state.
module attr_port_chk
    import attr_pkg::*;
#(
    parameter int DW  = ATTR_DW,
    parameter int NUM = ATTR_NUM,
    parameter int PAL = ATTR_PAL
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [ATTR_AW-1:0] bus_addr,
    input logic [DW-1:0]      bus_rdata,
    input logic               pal_disp_en,
    input logic [NUM*DW-1:0]  attr_q,
    input logic               phase_data
);
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (!phase_data && pal_disp_en && attr_q == '0)); // R1

    AST_PORT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_PORT) |=> (phase_data != $past(phase_data))); // R2

    AST_STATUS_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_STAT) |=> !phase_data); // R3

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_PORT && !phase_data) |=> $stable(pal_disp_en)); // R5

    AST_PAL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        pal_disp_en |=> $stable(attr_q[PAL*DW-1:0])); // R6

    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0)); // R10

    AST_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && bus_addr != A_PORT) |=>
            ($stable(attr_q) && phase_data == $past(phase_data))); // R10
endmodule

bind attr_port attr_port_chk #(.DW(DW), .NUM(NUM), .PAL(PAL)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .pal_disp_en (pal_disp_en),
    .attr_q      (attr_q),
    .phase_data  (phase_is_data)
);

// File: tb/attr_port_tb.sv
// Bench: table-driven accesses, then directed reset and boundary tests.
module attr_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 27;
    localparam logic [7:0] STAT = 8'hA5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [1:0]   bus_addr = '0;
    logic [7:0]   bus_wdata = '0;
    logic [7:0]   status_in = STAT;
    logic [7:0]   bus_rdata;
    logic         pal_disp_en;
    logic [167:0] attr_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    attr_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .status_in(status_in),
        .bus_rdata(bus_rdata), .pal_disp_en(pal_disp_en), .attr_q(attr_q)
    );

    // Vector: [23:20] requirement, [19:18] op (1 write, 2 read), [17:16] addr, [15:8] data, [7:0] expected
    localparam logic [23:0] VEC [NV] = '{
        {4'd3, 2'd2, 2'd2, 8'h00, 8'hA5},  // R3 status read
        {4'd2, 2'd1, 2'd0, 8'h03, 8'h00},  // R2 index 3
        {4'd4, 2'd2, 2'd0, 8'h00, 8'h03},  // R4 index readback
        {4'd2, 2'd1, 2'd0, 8'h5A, 8'h00},  // R2 data to reg 3
        {4'd2, 2'd2, 2'd1, 8'h00, 8'h5A},  // R2 readback reg 3
        {4'd4, 2'd2, 2'd0, 8'h00, 8'h03},  // R4 index kept
        {4'd5, 2'd1, 2'd0, 8'h23, 8'h00},  // R5 index 3, display owns
        {4'd5, 2'd2, 2'd0, 8'h00, 8'h23},  // R5 bit 5 latched
        {4'd6, 2'd1, 2'd0, 8'h77, 8'h00},  // R6 locked write
        {4'd6, 2'd2, 2'd1, 8'h00, 8'h5A},  // R6 reg 3 unchanged
        {4'd5, 2'd1, 2'd0, 8'hD2, 8'h00},  // R5 index 0x12, bits 7:6 dropped
        {4'd5, 2'd2, 2'd0, 8'h00, 8'h12},  // R5 readback
        {4'd7, 2'd1, 2'd0, 8'h3C, 8'h00},  // R7 data reg 0x12
        {4'd7, 2'd1, 2'd0, 8'h31, 8'h00},  // R7 index 0x11 with bit 5
        {4'd7, 2'd1, 2'd0, 8'h99, 8'h00},  // R7 data accepted
        {4'd7, 2'd2, 2'd1, 8'h00, 8'h99},  // R7 readback
        {4'd8, 2'd1, 2'd0, 8'h16, 8'h00},  // R8 index 0x16
        {4'd8, 2'd1, 2'd0, 8'h44, 8'h00},  // R8 discarded
        {4'd8, 2'd2, 2'd1, 8'h00, 8'h00},  // R8 reads zero
        {4'd3, 2'd1, 2'd0, 8'h04, 8'h00},  // R3 index 4, now data phase
        {4'd3, 2'd2, 2'd2, 8'h00, 8'hA5},  // R3 status rearms
        {4'd3, 2'd1, 2'd0, 8'h05, 8'h00},  // R3 taken as index 5
        {4'd3, 2'd2, 2'd0, 8'h00, 8'h05},  // R3 index readback
        {4'd10, 2'd1, 2'd1, 8'hEE, 8'h00}, // R10 stray write
        {4'd10, 2'd1, 2'd0, 8'h6B, 8'h00}, // R10 phase untouched: data reg 5
        {4'd10, 2'd2, 2'd1, 8'h00, 8'h6B}, // R10 readback
        {4'd10, 2'd2, 2'd3, 8'h00, 8'h00}  // R10 unused address
    };

    task automatic check(input logic [167:0] act, input logic [167:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One access: drive at negedge, sample reads before the edge.
    task automatic access(input logic [1:0] op, input logic [1:0] a, input logic [7:0] d,
                          input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_wr = (op == 2'd1);
        bus_rd = (op == 2'd2);
        bus_addr = a;
        bus_wdata = d;
        #1;
        if (op == 2'd2) check(168'(bus_rdata), 168'(exp), req);
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
        bus_rd = 1'b0;
    endtask

    initial begin
        logic [167:0] exp_q;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(168'(pal_disp_en), 168'd1, "R1");
        check(attr_q, '0, "R1");
        check(168'(bus_rdata), '0, "R10");
        rst_n = 1'b1;
        access(2'd2, 2'd0, 8'h00, 8'h20, "R1");

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][19:18], VEC[i][17:16], VEC[i][15:8], VEC[i][7:0],
                   $sformatf("R%0d vec%0d", VEC[i][23:20], i));
        end

        @(negedge clk);
        exp_q = '0;
        exp_q[3*8 +: 8]  = 8'h5A;
        exp_q[5*8 +: 8]  = 8'h6B;
        exp_q[17*8 +: 8] = 8'h99;
        exp_q[18*8 +: 8] = 8'h3C;
        check(attr_q, exp_q, "R9");
        check(168'(pal_disp_en), 168'd0, "R5");

        // R1 reset again clears everything
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(attr_q, '0, "R1");
        check(168'(pal_disp_en), 168'd1, "R1");
        rst_n = 1'b1;

        // R2 first write after reset is an index
        access(2'd1, 2'd0, 8'h0A, 8'h00, "R2");
        access(2'd1, 2'd0, 8'h11, 8'h00, "R2");
        access(2'd2, 2'd1, 8'h00, 8'h11, "R2");
        // R6 boundary 0x0F locked
        access(2'd1, 2'd0, 8'h2F, 8'h00, "R6");
        access(2'd1, 2'd0, 8'h12, 8'h00, "R6");
        access(2'd2, 2'd1, 8'h00, 8'h00, "R6");
        // R7 boundary 0x10 and 0x14 open while display owns palette
        access(2'd1, 2'd0, 8'h30, 8'h00, "R7");
        access(2'd1, 2'd0, 8'h5C, 8'h00, "R7");
        access(2'd2, 2'd1, 8'h00, 8'h5C, "R7");
        access(2'd1, 2'd0, 8'h34, 8'h00, "R7");
        access(2'd1, 2'd0, 8'hC3, 8'h00, "R7");
        access(2'd2, 2'd1, 8'h00, 8'hC3, "R7");
        // R8 boundary 0x15
        access(2'd1, 2'd0, 8'h15, 8'h00, "R8");
        access(2'd1, 2'd0, 8'h81, 8'h00, "R8");
        access(2'd2, 2'd1, 8'h00, 8'h00, "R8");

        @(negedge clk);
        exp_q = '0;
        exp_q[10*8 +: 8] = 8'h11;
        exp_q[16*8 +: 8] = 8'h5C;
        exp_q[20*8 +: 8] = 8'hC3;
        check(attr_q, exp_q, "R9");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule